// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Order

This block produces the word address that a synchronous SRAM core uses during burst accesses. An external address is captured when either of two address strobes fires. One strobe comes from the processor side and is honoured only while the chip enable is active. The other comes from the memory-controller side and always loads. After a load, the advance input steps a small beat counter. The low address bits then walk through a four-word group while the upper bits stay fixed.

The walk order is picked when the address is loaded. Linear order adds the beat count to the starting low bits, wrapping modulo four. Interleaved order XORs the beat count into the starting low bits. Bursting is optional: a new address can be loaded on any cycle, back to back, with no idle cycles.

The block outputs the full current address and the beat index to the SRAM datapath. Both are driven from registers, so each load or advance shows up one clock after the edge that samples it.

Top module: `bseq_top`

## Requirements
- R1: While reset is asserted, and right after it, addr_out is all zeros and beat_idx is 0.
- R2: When strobe_ctrl is 1 at a clock edge, after that edge addr_out equals the ext_addr sampled there and beat_idx is 0, whatever the value of chip_en.
- R3: strobe_proc loads ext_addr only when chip_en is 1 at the same edge. With chip_en at 0, strobe_ctrl at 0 and adv at 0, addr_out and beat_idx do not change.
- R4: At an edge with adv at 1 and no load, beat_idx increases by one modulo 4. At an edge with neither a load nor adv, addr_out and beat_idx hold.
- R5: If order_sel was 0 (linear) at the load, the low two bits of addr_out equal (loaded low two bits + beat_idx) modulo 4.
- R6: If order_sel was 1 (interleaved) at the load, the low two bits of addr_out equal the loaded low two bits XOR beat_idx.
- R7: Between loads, addr_out bits above bit 1 stay equal to the loaded address.
- R8: If a load and adv occur at the same edge, the load wins and beat_idx becomes 0.
- R9: After the fourth beat, one more advance returns addr_out to the loaded start address in the same four-word group.
- R10: order_sel is sampled only at a load. Changing it during a burst does not change the sequence.
- R11: Loads on consecutive cycles each take effect one cycle later, with no lost or delayed address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | ADDR_W | Externally supplied start address |
| strobe_proc | input | 1 | Processor-side load strobe, gated by chip_en |
| strobe_ctrl | input | 1 | Controller-side load strobe, always loads |
| chip_en | input | 1 | Chip enable qualifying strobe_proc |
| adv | input | 1 | Advance the burst by one beat |
| order_sel | input | 1 | 0 linear, 1 interleaved; sampled at load |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | BEAT_W | Beat number within the current burst |

## Verification
The bound checker watches every cycle for the loading rules: the controller strobe always loads, the processor strobe is gated by chip enable, and a load beats a same-cycle advance. It also checks that the counter steps by exactly one per advance and that the upper address bits are stable and nothing moves when idle. The checker does not know the order captured at load time. So the linear and interleaved sequences, the wrap back to the start word, and the fact that order_sel is ignored mid-burst are shown by the bench's scenarios and its reference model.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

   // Burst walk order, captured at each load
   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } bseq_order_e;

   // Build-time choice of which orders the mapper implements
   localparam int unsigned ORDER_BOTH        = 0;
   localparam int unsigned ORDER_LINEAR_ONLY = 1;
   localparam int unsigned ORDER_XOR_ONLY    = 2;

endpackage

// File: rtl/bseq_load_arb.sv
module bseq_load_arb (
   input  logic strobe_proc,
   input  logic strobe_ctrl,
   input  logic chip_en,
   input  logic adv,
   output logic load_now,
   output logic step_now
);

   logic proc_ok;

   always_comb begin
      proc_ok  = strobe_proc & chip_en;
      load_now = strobe_ctrl | proc_ok;
      // a load takes priority over an advance in the same cycle
      step_now = adv & ~load_now;
   end

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   output logic [BEAT_W-1:0] beat_q
);

   localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (clear) begin
         beat_q <= '0;
      end else if (step) begin
         // natural wrap inside the burst group
         beat_q <= beat_q + BEAT_ONE;
      end
   end

endmodule

// File: rtl/bseq_addr_hold.sv
module bseq_addr_hold
   import bseq_pkg::*;
#(
   parameter int unsigned ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic              d_order,
   output logic [ADDR_W-1:0] base_q,
   output bseq_order_e       order_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         order_q <= ORD_LINEAR;
      end else if (load) begin
         base_q  <= d_addr;
         order_q <= bseq_order_e'(d_order);
      end
   end

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
   import bseq_pkg::*;
#(
   parameter int unsigned BEAT_W        = 2,
   parameter int unsigned ORDER_SUPPORT = ORDER_BOTH
) (
   input  logic [BEAT_W-1:0] start_low,
   input  logic [BEAT_W-1:0] beat,
   input  bseq_order_e       order,
   output logic [BEAT_W-1:0] low_out
);

   logic [BEAT_W-1:0] lin_low;
   logic [BEAT_W-1:0] xor_low;

   // linear: modulo add inside the group
   always_comb lin_low = start_low + beat;

   // interleaved: per-bit toggle by the beat count
   for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
      assign xor_low[b] = start_low[b] ^ beat[b];
   end

   if (ORDER_SUPPORT == ORDER_LINEAR_ONLY) begin : g_lin
      logic unused_sel;
      assign unused_sel = ^{order, xor_low};
      assign low_out    = lin_low;
   end else if (ORDER_SUPPORT == ORDER_XOR_ONLY) begin : g_xor
      logic unused_sel;
      assign unused_sel = ^{order, lin_low};
      assign low_out    = xor_low;
   end else begin : g_both
      always_comb begin
         unique case (order)
            ORD_XOR:    low_out = xor_low;
            default:    low_out = lin_low;
         endcase
      end
   end

endmodule

// File: rtl/bseq_top.sv
module bseq_top
   import bseq_pkg::*;
#(
   parameter int unsigned ADDR_W        = 18,
   parameter int unsigned BEAT_W        = 2,
   parameter int unsigned ORDER_SUPPORT = ORDER_BOTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              strobe_proc,
   input  logic              strobe_ctrl,
   input  logic              chip_en,
   input  logic              adv,
   input  logic              order_sel,
   output logic [ADDR_W-1:0] addr_out,
   output logic [BEAT_W-1:0] beat_idx
);

   localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

   // elaboration-time parameter checks
   if (BEAT_W < 1) begin : g_bad_beat
      $error("bseq_top: BEAT_W must be at least 1");
   end
   if (ADDR_W <= BEAT_W) begin : g_bad_addr
      $error("bseq_top: ADDR_W must exceed BEAT_W");
   end
   if (ORDER_SUPPORT > ORDER_XOR_ONLY) begin : g_bad_order
      $error("bseq_top: ORDER_SUPPORT out of range");
   end

   logic              load_now;
   logic              step_now;
   logic [ADDR_W-1:0] base_q;
   bseq_order_e       order_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] low_bits;

   bseq_load_arb u_arb (
      .strobe_proc (strobe_proc),
      .strobe_ctrl (strobe_ctrl),
      .chip_en     (chip_en),
      .adv         (adv),
      .load_now    (load_now),
      .step_now    (step_now)
   );

   bseq_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_now),
      .d_addr  (ext_addr),
      .d_order (order_sel),
      .base_q  (base_q),
      .order_q (order_q)
   );

   bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (load_now),
      .step   (step_now),
      .beat_q (beat_q)
   );

   bseq_order_map #(
      .BEAT_W        (BEAT_W),
      .ORDER_SUPPORT (ORDER_SUPPORT)
   ) u_map (
      .start_low (base_q[BEAT_W-1:0]),
      .beat      (beat_q),
      .order     (order_q),
      .low_out   (low_bits)
   );

   logic [UPPER_W-1:0] upper_bits;
   assign upper_bits = base_q[ADDR_W-1:BEAT_W];
   assign addr_out   = {upper_bits, low_bits};
   assign beat_idx   = beat_q;

endmodule

// File: rtl/bseq_top_chk.sv
module bseq_top_chk #(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              strobe_proc,
   input logic              strobe_ctrl,
   input logic              chip_en,
   input logic              adv,
   input logic              order_sel,
   input logic [ADDR_W-1:0] addr_out,
   input logic [BEAT_W-1:0] beat_idx
);

   logic any_load;
   logic unused_in;
   assign any_load  = strobe_ctrl | (strobe_proc & chip_en);
   assign unused_in = order_sel;

   // R1
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |=> (addr_out == '0) && (beat_idx == '0));

   // R2
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_ctrl |=> (addr_out == $past(ext_addr)) && (beat_idx == '0));

   // R3
   proc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_proc && !chip_en && !strobe_ctrl && !adv)
      |=> $stable(addr_out) && $stable(beat_idx));

   // R3
   proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_proc && chip_en) |=> (addr_out == $past(ext_addr)));

   // R4
   beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_load && adv) |=> beat_idx == BEAT_W'($past(beat_idx) + 1'b1));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_load && !adv) |=> $stable(addr_out) && $stable(beat_idx));

   // R7
   upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

   // R8
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_load && adv) |=> beat_idx == '0);

endmodule

bind bseq_top bseq_top_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ext_addr    (ext_addr),
   .strobe_proc (strobe_proc),
   .strobe_ctrl (strobe_ctrl),
   .chip_en     (chip_en),
   .adv         (adv),
   .order_sel   (order_sel),
   .addr_out    (addr_out),
   .beat_idx    (beat_idx)
);

// File: tb/sim_bseq_top.sv
`timescale 1ns/1ps
module sim_bseq_top;

   localparam int unsigned AW = 18;
   localparam int unsigned BW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic          strobe_proc = 1'b0;
   logic          strobe_ctrl = 1'b0;
   logic          chip_en = 1'b0;
   logic          adv = 1'b0;
   logic          order_sel = 1'b0;
   logic [AW-1:0] addr_out;
   logic [BW-1:0] beat_idx;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference state
   logic [AW-1:0] m_base = '0;
   logic [BW-1:0] m_beat = '0;
   logic          m_ord  = 1'b0;

   always #2 clk = ~clk;

   bseq_top #(.ADDR_W(AW), .BEAT_W(BW)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext_addr    (ext_addr),
      .strobe_proc (strobe_proc),
      .strobe_ctrl (strobe_ctrl),
      .chip_en     (chip_en),
      .adv         (adv),
      .order_sel   (order_sel),
      .addr_out    (addr_out),
      .beat_idx    (beat_idx)
   );

   function automatic logic [BW-1:0] map_low(input logic [BW-1:0] s,
                                             input logic [BW-1:0] b,
                                             input logic o);
      return o ? (s ^ b) : BW'(s + b);
   endfunction

   function automatic logic [AW-1:0] exp_addr();
      return {m_base[AW-1:BW], map_low(m_base[BW-1:0], m_beat, m_ord)};
   endfunction

   task automatic chk(input string tag, input logic [AW-1:0] act,
                      input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at negedge, model at posedge, sample at the next negedge
   task automatic step(input string tag, input logic [AW-1:0] ea,
                       input logic sp, input logic sc, input logic ce,
                       input logic av, input logic os);
      ext_addr = ea; strobe_proc = sp; strobe_ctrl = sc;
      chip_en = ce; adv = av; order_sel = os;
      @(posedge clk);
      if (sc || (sp && ce)) begin
         m_base = ea; m_beat = '0; m_ord = os;
      end else if (av) begin
         m_beat = m_beat + 1'b1;
      end
      @(negedge clk);
      chk({tag, " addr"}, addr_out, exp_addr());
      chk({tag, " beat"}, {{(AW-BW){1'b0}}, beat_idx}, {{(AW-BW){1'b0}}, m_beat});
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7315));
      repeat (3) @(negedge clk);
      // R1 during and after reset
      chk("R1 in reset", addr_out, '0);
      rst_n = 1'b1;
      chk("R1 beat", {{(AW-BW){1'b0}}, beat_idx}, '0);
      step("R1 idle after reset", 18'h3ffff, 0, 0, 0, 0, 0);

      // R2 controller strobe loads with chip enable off
      step("R2", 18'h12345, 0, 1, 0, 0, 0);
      // R3 processor strobe gated off
      step("R3 gated", 18'h2aaaa, 1, 0, 0, 0, 0);
      step("R3 enabled", 18'h2aaaa, 1, 0, 1, 0, 0);

      // R5 linear from low=2, R7 upper held, R9 wrap
      step("R5 load", 18'h0abc6, 0, 1, 0, 0, 0);
      step("R5 b1", 18'h3ffff, 0, 0, 1, 1, 1);
      step("R5 b2", 18'h00000, 0, 0, 1, 1, 0);
      step("R5 R7 b3", 18'h11111, 0, 0, 0, 1, 1);
      step("R9 linear wrap", 18'h22222, 0, 0, 0, 1, 0);
      step("R4 hold", 18'h22222, 0, 0, 0, 0, 0);

      // R6 interleaved from low=1, R10 toggling order mid-burst
      step("R6 load", 18'h35551, 1, 0, 1, 0, 1);
      step("R6 R10 b1", 18'h0, 0, 0, 1, 1, 0);
      step("R6 b2", 18'h0, 0, 0, 1, 1, 1);
      step("R6 R10 b3", 18'h0, 0, 0, 1, 1, 0);
      step("R9 interleave wrap", 18'h0, 0, 0, 1, 1, 0);

      // R8 load and advance together
      step("R8 pre", 18'h0, 0, 0, 0, 1, 0);
      step("R8", 18'h01233, 1, 0, 1, 1, 0);
      step("R8 ctrl", 18'h04567, 0, 1, 0, 1, 1);

      // R11 back-to-back loads
      step("R11 a", 18'h10000, 0, 1, 0, 0, 0);
      step("R11 b", 18'h20001, 1, 0, 1, 0, 1);
      step("R11 c", 18'h30002, 0, 1, 1, 1, 0);

      // constrained random mix
      for (int i = 0; i < 800; i++) begin
         step("R4 R5 R6 random", AW'($urandom),
              ($urandom % 5) == 0, ($urandom % 7) == 0,
              ($urandom % 2) == 1, ($urandom % 3) != 0,
              ($urandom % 2) == 1);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule